// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps wall-clock time and calendar date as packed BCD bytes and advances them from a one-pulse-per-second input. A host reaches sixteen byte registers through a small access port. A start strobe loads an address. Each read or write strobe then uses the current address and moves it on by one, so a single start is enough to sweep several registers in a row.

The host never touches the running counters directly. A holding copy sits between the host and the counters. While neither the freeze bit nor the write bit is set, the copy refreshes from the counters every cycle, all fields together. Setting the freeze bit stops the refresh, so the host can read all seven fields as one consistent time. Setting the write bit opens the time and spare registers to host writes. Time writes then land in the holding copy. When the host clears the write bit, the whole copy is loaded into the running counters in one edge.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the time reads seconds 00, minutes 00, hours 00, day of week 01, day of month 01, month 01, year 00, and the control register reads 0x00.
- R2: The register map is as follows. 0x00 is control, with bit 0 as freeze and bit 1 as write. 0x01 to 0x08 are spare bytes. The time fields are seconds at 0x09, minutes at 0x0A, hours at 0x0B, day of week at 0x0C, day of month at 0x0D, month at 0x0E and year at 0x0F. A cycle with `acc_start` high uses `acc_addr` as its address. Every other cycle uses the internal pointer. Each read or write moves the pointer to that address plus one, wrapping from 0x0F to 0x00.
- R3: `rd_data` carries the addressed byte in the cycle after `acc_rd`, with `rd_valid` high in that cycle.
- R4: Each tick advances seconds in BCD. Seconds and minutes count 00 to 59 and carry on wrap. Hours count 00 to 23 and carry into the date on wrap.
- R5: Day of week counts 01 to 07. It returns to 01 after 07 when the hours wrap.
- R6: Day of month returns to 01 after the last day of the month and carries into the month. Months 04, 06, 09 and 11 end at 30. Month 02 ends at 29 when the year is a multiple of 4, with 00 counting as a multiple of 4, and at 28 otherwise. All other months end at 31. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: Bits a field cannot use read as 0. These are bits 7:5 of month, 7:6 of day of month and hours, 7:3 of day of week, bit 7 of minutes and seconds, and bits 7:2 of control.
- R8: While the write bit is clear, writes to 0x01 through 0x0F have no effect.
- R9: While the write bit is set, time writes go to the holding copy, and reads return the written values even across ticks. A control write that clears the write bit copies all time fields into the running counters.
- R10: While freeze is set, reads of the time fields keep returning the values held when freeze was set, even across ticks. After freeze clears, the reads follow the running counters again.
- R11: The time fields change only on a cycle with `tick` high, or on the transfer of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second |
| acc_start | input | 1 | Take `acc_addr` as this cycle's address |
| acc_addr | input | 4 | Start address of a burst |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds a result |

## Verification
The checker watches several rules on every cycle. It checks the pointer step and its wrap, and the one-cycle read latency. It checks that seconds move only on a tick and always move on one. It checks that the holding copy stays still while frozen and that the unused month bits stay zero. Only the bench scenarios can show the calendar arithmetic. That covers the carry chain, month lengths and leap years, day-of-week wrap and year wrap. The bench also shows that locked writes are ignored and that the deferred load takes effect when the write bit clears.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{yr: 8'h00, mon: 8'h01, dom: 8'h01,
                                      dow: 8'h01, hr: 8'h00, min: 8'h00,
                                      sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 = 2 mod 4, so tens*2 + units decides divisibility by 4
  function automatic logic leap_year(input logic [7:0] y);
    logic [5:0] r;
    r = {1'b0, y[7:4], 1'b0} + {2'b0, y[3:0]};
    return r[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // index 0 = seconds ... 6 = year
  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rtc_burst_ptr.sv
module rtc_burst_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr
);
  assign eff_addr = start ? start_addr : ptr;

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (step)  ptr <= eff_addr + AW'(1);
    else if (start) ptr <= start_addr;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    nxt   = now;
    c_min = now.sec == 8'h59;
    c_hr  = c_min && now.min == 8'h59;
    c_day = c_hr && now.hr == 8'h23;
    c_mon = c_day && now.dom == month_end(now.mon, now.yr);
    c_yr  = c_mon && now.mon == 8'h12;
    if (tick) begin
      nxt.sec = c_min ? 8'h00 : bcd_inc(now.sec);
      if (c_min) nxt.min = (now.min == 8'h59) ? 8'h00 : bcd_inc(now.min);
      if (c_hr)  nxt.hr  = (now.hr == 8'h23) ? 8'h00 : bcd_inc(now.hr);
      if (c_day) begin
        nxt.dow = (now.dow == 8'h07) ? 8'h01 : bcd_inc(now.dow);
        nxt.dom = c_mon ? 8'h01 : bcd_inc(now.dom);
      end
      if (c_mon) nxt.mon = c_yr ? 8'h01 : bcd_inc(now.mon);
      if (c_yr)  nxt.yr  = (now.yr == 8'h99) ? 8'h00 : bcd_inc(now.yr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= RTC_RESET;
    else if (load) now <= load_val;
    else           now <= nxt;
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int TIME_BASE = 9,
  parameter int DW        = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    acc_start,
  input  logic [$clog2(NREG)-1:0] acc_addr,
  input  logic                    acc_rd,
  input  logic                    acc_wr,
  input  logic [DW-1:0]           acc_wdata,
  output logic [DW-1:0]           rd_data,
  output logic                    rd_valid
);
  localparam int AW     = $clog2(NREG);
  localparam int NTIME  = NREG - TIME_BASE;
  localparam int NSPARE = TIME_BASE - 1;

  logic [AW-1:0]   eff_addr, ptr, toff;
  logic            ctrl_freeze, ctrl_wen;
  logic            wr_ctrl, wr_spare, wr_time, load_live;
  logic [DW-1:0]   hold  [NTIME];
  logic [DW-1:0]   spare [NSPARE];
  logic [8*NTIME-1:0] hold_flat;
  rtc_time_t       live_now, hold_time;
  logic [DW-1:0]   rd_mux;

  rtc_burst_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .start(acc_start), .start_addr(acc_addr),
    .step(acc_rd | acc_wr), .eff_addr(eff_addr), .ptr(ptr)
  );

  assign toff      = eff_addr - AW'(TIME_BASE);
  assign wr_ctrl   = acc_wr && eff_addr == '0;
  assign wr_spare  = acc_wr && ctrl_wen && eff_addr != '0 && eff_addr < AW'(TIME_BASE);
  assign wr_time   = acc_wr && ctrl_wen && eff_addr >= AW'(TIME_BASE);
  assign load_live = wr_ctrl && ctrl_wen && !acc_wdata[1];

  genvar gi;
  generate
    for (gi = 0; gi < NTIME; gi++) begin : g_flat
      assign hold_flat[8*gi +: 8] = hold[gi];
    end
  endgenerate
  assign hold_time = rtc_time_t'(hold_flat);

  rtc_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(load_live),
    .load_val(hold_time), .now(live_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_freeze <= 1'b0;
      ctrl_wen    <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_freeze <= acc_wdata[0];
      ctrl_wen    <= acc_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NTIME; i++) begin
      if (rst)
        hold[i] <= RTC_RESET[8*i +: 8];
      else if (!ctrl_freeze && !ctrl_wen)
        hold[i] <= live_now[8*i +: 8];
      else if (wr_time && toff == AW'(i))
        hold[i] <= acc_wdata & field_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSPARE; i++) begin
      if (rst)                                  spare[i] <= '0;
      else if (wr_spare && eff_addr == AW'(i + 1)) spare[i] <= acc_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (eff_addr == '0)
      rd_mux = {{(DW-2){1'b0}}, ctrl_wen, ctrl_freeze};
    else if (eff_addr < AW'(TIME_BASE))
      rd_mux = spare[eff_addr - AW'(1)];
    else
      rd_mux = hold[toff];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int AW = 4,
  parameter int HW = 56
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          acc_rd,
  input logic          acc_wr,
  input logic          rd_valid,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] ptr,
  input logic          ctrl_freeze,
  input logic          load_live,
  input logic [7:0]    live_sec,
  input logic [HW-1:0] hold_flat
);
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) |=> ptr == AW'($past(eff_addr) + AW'(1))); // R2

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> rd_valid); // R3

  AST_SEC_MOVES: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_live) |=> live_sec != $past(live_sec)); // R4

  AST_SEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_live) |=> $stable(live_sec)); // R11

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_freeze && !acc_wr) |=> $stable(hold_flat)); // R10

  AST_MON_UNUSED: assert property (@(posedge clk) disable iff (rst)
    hold_flat[47:45] == 3'b000); // R7
endmodule

bind rtc_regfile rtc_regfile_chk #(.AW(AW), .HW(8*NTIME)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .rd_valid(rd_valid), .eff_addr(eff_addr), .ptr(ptr),
  .ctrl_freeze(ctrl_freeze), .load_live(load_live),
  .live_sec(live_now.sec), .hold_flat(hold_flat)
);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int NVEC       = 12;

  // {initial time, expected after one tick}, each {yr,mon,dom,dow,hr,min,sec}
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00010101000000, 56'h00010101000001},
    {56'h00010101000059, 56'h00010101000100},
    {56'h00010101095959, 56'h00010101100000},
    {56'h21031507235959, 56'h21031601000000},
    {56'h23022803235959, 56'h23030104000000},
    {56'h24022803235959, 56'h24022904000000},
    {56'h24043002235959, 56'h24050103000000},
    {56'h99123105235959, 56'h00010106000000},
    {56'h10113006235959, 56'h10120107000000},
    {56'h00022901235959, 56'h00030102000000},
    {56'h05013104235959, 56'h05020105000000},
    {56'h12063007235959, 56'h12070101000000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       acc_start = 1'b0;
  logic [3:0] acc_addr = '0;
  logic       acc_rd = 1'b0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile u0 (
    .clk(clk), .rst(rst), .tick(tick), .acc_start(acc_start),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit st, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_start = st; acc_addr = a; acc_wr = 1'b1; acc_wdata = d;
    @(negedge clk);
    acc_start = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd_byte(input bit st, input logic [3:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    acc_start = st; acc_addr = a; acc_rd = 1'b1;
    @(negedge clk);
    acc_start = 1'b0; acc_rd = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(input logic [55:0] t);
    wr_byte(1'b1, 4'h0, 8'h02);
    for (int i = 0; i < 7; i++) wr_byte(i == 0, 4'h9, t[8*i +: 8]);
    wr_byte(1'b1, 4'h0, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  task automatic get_time(output logic [55:0] t);
    logic [7:0] d; logic v;
    for (int i = 0; i < 7; i++) begin
      rd_byte(i == 0, 4'h9, d, v);
      t[8*i +: 8] = d;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  d;
    logic        v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    get_time(t);
    check("R1 time", {8'h0, t}, {8'h0, 56'h00010101000000});
    rd_byte(1'b1, 4'h0, d, v);
    check("R1 ctrl", {56'h0, d}, 64'h0);
    // R3 read strobe gives valid next cycle
    check("R3 valid", {63'h0, v}, 64'h1);

    // R11 no tick, no change
    repeat (20) @(negedge clk);
    get_time(t);
    check("R11 idle", {8'h0, t}, {8'h0, 56'h00010101000000});

    // R8 locked writes ignored
    wr_byte(1'b1, 4'h3, 8'h5A);
    wr_byte(1'b1, 4'h9, 8'h42);
    rd_byte(1'b1, 4'h3, d, v);
    check("R8 spare", {56'h0, d}, 64'h0);
    rd_byte(1'b1, 4'h9, d, v);
    check("R8 sec", {56'h0, d}, 64'h0);

    // R2 spare writable with write bit set
    wr_byte(1'b1, 4'h0, 8'h02);
    wr_byte(1'b1, 4'h3, 8'h5A);
    wr_byte(1'b0, 4'h0, 8'hC3);
    rd_byte(1'b1, 4'h3, d, v);
    check("R2 spare3", {56'h0, d}, 64'h5A);
    rd_byte(1'b0, 4'h0, d, v);
    check("R2 spare4 step", {56'h0, d}, 64'hC3);

    // R7 unused bits masked
    wr_byte(1'b1, 4'hE, 8'hFF);
    wr_byte(1'b1, 4'hC, 8'hFF);
    rd_byte(1'b1, 4'hE, d, v);
    check("R7 month", {56'h0, d}, 64'h1F);
    rd_byte(1'b1, 4'hC, d, v);
    check("R7 dow", {56'h0, d}, 64'h07);
    rd_byte(1'b1, 4'h0, d, v);
    check("R7 ctrl", {56'h0, d}, 64'h02);
    wr_byte(1'b1, 4'hE, 8'h01);
    wr_byte(1'b1, 4'hC, 8'h01);
    wr_byte(1'b1, 4'h0, 8'h00);

    // table: R4 R5 R6 carries
    for (int k = 0; k < NVEC; k++) begin
      set_time(VEC[k][111:56]);
      pulse_tick();
      get_time(t);
      check($sformatf("R4 R5 R6 vec%0d", k), {8'h0, t}, {8'h0, VEC[k][55:0]});
    end

    // R9 deferred load through holding copy
    set_time(56'h12030405061020);
    wr_byte(1'b1, 4'h0, 8'h02);
    wr_byte(1'b1, 4'h9, 8'h30);
    pulse_tick();
    rd_byte(1'b1, 4'h9, d, v);
    check("R9 hold", {56'h0, d}, 64'h30);
    wr_byte(1'b1, 4'h0, 8'h00);
    repeat (2) @(negedge clk);
    get_time(t);
    check("R9 load", {8'h0, t}, {8'h0, 56'h12030405061030});
    pulse_tick();
    rd_byte(1'b1, 4'h9, d, v);
    check("R9 runs", {56'h0, d}, 64'h31);

    // R10 freeze
    wr_byte(1'b1, 4'h0, 8'h01);
    pulse_tick();
    pulse_tick();
    get_time(t);
    check("R10 frozen", {8'h0, t}, {8'h0, 56'h12030405061031});
    // R2 wrap from 0x0F to 0x00
    rd_byte(1'b1, 4'hF, d, v);
    check("R2 yr", {56'h0, d}, 64'h12);
    rd_byte(1'b0, 4'h0, d, v);
    check("R2 wrap", {56'h0, d}, 64'h01);
    wr_byte(1'b1, 4'h0, 8'h00);
    repeat (2) @(negedge clk);
    rd_byte(1'b1, 4'h9, d, v);
    check("R10 release", {56'h0, d}, 64'h33);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule